// File: doc/BRIEF.md
# Data Access Checker with Data Breakpoints

This block sits beside the load/store path of a processor core. It sees each data access as an address, a store flag and a valid strobe. It then makes three decisions about that access, using control state that the system control registers supply.

First, it may place a process identifier into the top address bits. This happens only when the incoming address lies in the lowest address slot and the identifier is non-zero. The rewritten address leaves the block combinationally.

Second, it raises an alignment abort for a misaligned access when alignment checking is enabled. In that case it captures a fault status code and the faulting address.

Third, it compares the access with two data breakpoint address registers. Each breakpoint has its own access-kind enable, and each does a word-granular match. In mask mode the second register instead becomes an inverse mask on the first. A hit raises a breakpoint event and writes a data-breakpoint entry code into a debug status register.

The block owns the fault status, fault address and debug status registers. Outside logic can request that fault information be recorded, but such a request takes effect only while the debug status top bit is set.

Top module: `mem_access_checker`

## Requirements
- R1: In the cycle after a synchronous reset, `abort_o`, `bp_event_o`, `fsr_o`, `far_o` and `dsr_o` are all zero.
- R2: `out_addr` equals `acc_addr` with `pid_bits` ORed into bits [31:25]. This happens in the same cycle, when `pid_bits` is non-zero and `acc_addr[31:25]` is zero. Bits [24:0] always pass through unchanged.
- R3: When `pid_bits` is zero, or `acc_addr[31:25]` is non-zero, `out_addr` equals `acc_addr`.
- R4: Suppose `acc_valid`, `ctrl_align_en` and a non-zero address bits [1:0] occur together. Then one clock later `abort_o` pulses for one cycle, `fsr_o` holds 32'h0000_0001 and `far_o` holds the rewritten address. When `ctrl_align_en` is low, a misaligned access raises no abort.
- R5: The 2-bit breakpoint enables are coded as follows: 0 is off, 1 matches stores only, 2 matches any access, and 3 matches loads only.
- R6: When `bp_mask_mode` is 0, breakpoint 0 hits if rewritten address bits [31:2] equal `bp_addr0[31:2]` under `bp_en0`. Breakpoint 1 does the same with `bp_addr1` and `bp_en1`. Address bits [1:0] are ignored.
- R7: When `bp_mask_mode` is 1, a hit needs `bp_en0` to accept the access kind and (address AND NOT `bp_addr1`) to equal (`bp_addr0` AND NOT `bp_addr1`). `bp_en1` has no effect in this mode.
- R8: A hit on a valid access makes `bp_event_o` pulse one clock later. In that same update, `dsr_o[4:2]` becomes 3'b010 and the other `dsr_o` bits keep their values.
- R9: `rec_req` loads `rec_fsr` AND 32'h0000_06FF into `fsr_o` and `rec_far` into `far_o`, but only while `dsr_o[31]` is 1. An alignment abort in the same cycle takes priority over it.
- R10: `dsr_wr_en` loads `dsr_wr_data` into `dsr_o` one clock later. A breakpoint hit in the same cycle still forces bits [4:2] to the entry code.
- R11: An access that is both misaligned and a breakpoint hit raises `abort_o` and `bp_event_o` in the same cycle.
- R12: Alignment checks, breakpoint comparisons and the captured fault address all use the rewritten address, not the incoming one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Incoming access address |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| pid_bits | input | 7 | Process identifier for the top address bits |
| ctrl_align_en | input | 1 | Alignment checking enable |
| bp_addr0 | input | 32 | Breakpoint address register 0 |
| bp_addr1 | input | 32 | Breakpoint address register 1 or inverse mask |
| bp_en0 | input | 2 | Access-kind enable of breakpoint 0 |
| bp_en1 | input | 2 | Access-kind enable of breakpoint 1 |
| bp_mask_mode | input | 1 | Selects the masked single-breakpoint mode |
| dsr_wr_en | input | 1 | Debug status write strobe |
| dsr_wr_data | input | 32 | Debug status write value |
| rec_req | input | 1 | Outside request to record fault information |
| rec_fsr | input | 32 | Fault status value to record |
| rec_far | input | 32 | Fault address value to record |
| out_addr | output | 32 | Address after process-ID insertion |
| abort_o | output | 1 | Alignment abort pulse |
| bp_event_o | output | 1 | Data breakpoint event pulse |
| fsr_o | output | 32 | Fault status register |
| far_o | output | 32 | Fault address register |
| dsr_o | output | 32 | Debug status register |

## Verification
The bench goes after several corner cases, each of which would expose a specific mistake:
- An address that only matches a breakpoint after the process-ID rewrite; a design that compared the raw address would miss the event.
- Loads and stores against each enable code; a swapped store/load encoding would show up here.
- Mask mode with the second enable set and an address equal to the second register; a design that still consulted `bp_en1` there would raise a false event.
- Record requests with the debug status top bit clear, and again with an alignment abort in the same cycle; these expose a recording gate that is ignored or a wrong priority between the two writers.
- A debug status write that lands together with a hit; this shows whether the entry code is lost.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    BPK_OFF   = 2'd0,
    BPK_STORE = 2'd1,
    BPK_ANY   = 2'd2,
    BPK_LOAD  = 2'd3
  } bp_kind_e;

  localparam int DSR_REC_BIT  = 31;
  localparam int DSR_CODE_LSB = 2;
  localparam int DSR_CODE_W   = 3;

  function automatic logic kind_accepts(input logic [1:0] en, input logic is_store);
    logic ok;
    case (bp_kind_e'(en))
      BPK_STORE: ok = is_store;
      BPK_LOAD:  ok = !is_store;
      BPK_ANY:   ok = 1'b1;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/mac_pid_remap.sv
module mac_pid_remap #(
  parameter int AW    = 32,
  parameter int PID_W = 7
) (
  input  logic [AW-1:0]    addr_in,
  input  logic [PID_W-1:0] pid,
  output logic [AW-1:0]    addr_out
);
  localparam int LOW_W = AW - PID_W;

  logic in_low_slot;
  logic pid_live;

  always_comb begin
    in_low_slot = (addr_in[AW-1:LOW_W] == '0);
    pid_live    = (pid != '0);
    if (in_low_slot && pid_live)
      addr_out = {pid, addr_in[LOW_W-1:0]};
    else
      addr_out = addr_in;
  end
endmodule

// File: rtl/mac_dbp_match.sv
module mac_dbp_match #(
  parameter int AW       = 32,
  parameter int GRAN_LSB = 2,
  parameter int NUM_BP   = 2
) (
  input  logic                    valid,
  input  logic [AW-1:0]           addr,
  input  logic                    is_store,
  input  logic [NUM_BP-1:0][AW-1:0] refs,
  input  logic [NUM_BP-1:0][1:0]  ens,
  input  logic                    mask_mode,
  output logic                    hit
);
  import mac_pkg::*;

  logic [NUM_BP-1:0] word_hit;
  logic              masked_hit;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_word
    logic same_word;
    assign same_word   = (addr[AW-1:GRAN_LSB] == refs[g][AW-1:GRAN_LSB]);
    assign word_hit[g] = same_word && kind_accepts(ens[g], is_store);
  end

  always_comb begin
    masked_hit = kind_accepts(ens[0], is_store) &&
                 ((addr & ~refs[1]) == (refs[0] & ~refs[1]));
  end

  assign hit = valid && (mask_mode ? masked_hit : (word_hit != '0));
endmodule

// File: rtl/mac_status_regs.sv
module mac_status_regs #(
  parameter int          AW         = 32,
  parameter logic [31:0] FSR_MASK   = 32'h0000_06FF,
  parameter logic [31:0] ALIGN_CODE = 32'h0000_0001,
  parameter logic [2:0]  DB_CODE    = 3'b010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          align_fault,
  input  logic          bp_hit,
  input  logic [AW-1:0] fault_addr,
  input  logic          dsr_wr_en,
  input  logic [31:0]   dsr_wr_data,
  input  logic          rec_req,
  input  logic [31:0]   rec_fsr,
  input  logic [AW-1:0] rec_far,
  output logic          abort_o,
  output logic          bp_event_o,
  output logic [31:0]   fsr_o,
  output logic [AW-1:0] far_o,
  output logic [31:0]   dsr_o
);
  import mac_pkg::*;

  logic [31:0] dsr_next;
  logic        rec_ok;

  assign rec_ok = rec_req && dsr_o[DSR_REC_BIT];

  always_comb begin
    dsr_next = dsr_wr_en ? dsr_wr_data : dsr_o;
    if (bp_hit)
      dsr_next[DSR_CODE_LSB +: DSR_CODE_W] = DB_CODE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_o    <= 1'b0;
      bp_event_o <= 1'b0;
      fsr_o      <= '0;
      far_o      <= '0;
      dsr_o      <= '0;
    end else begin
      abort_o    <= align_fault;
      bp_event_o <= bp_hit;
      dsr_o      <= dsr_next;
      if (align_fault) begin
        fsr_o <= ALIGN_CODE & FSR_MASK;
        far_o <= fault_addr;
      end else if (rec_ok) begin
        fsr_o <= rec_fsr & FSR_MASK;
        far_o <= rec_far;
      end
    end
  end
endmodule

// File: rtl/mem_access_checker.sv
module mem_access_checker #(
  parameter int          AW         = 32,
  parameter int          PID_W      = 7,
  parameter int          GRAN_LSB   = 2,
  parameter logic [31:0] FSR_MASK   = 32'h0000_06FF,
  parameter logic [31:0] ALIGN_CODE = 32'h0000_0001,
  parameter logic [2:0]  DB_CODE    = 3'b010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [AW-1:0]    acc_addr,
  input  logic             acc_store,
  input  logic [PID_W-1:0] pid_bits,
  input  logic             ctrl_align_en,
  input  logic [AW-1:0]    bp_addr0,
  input  logic [AW-1:0]    bp_addr1,
  input  logic [1:0]       bp_en0,
  input  logic [1:0]       bp_en1,
  input  logic             bp_mask_mode,
  input  logic             dsr_wr_en,
  input  logic [31:0]      dsr_wr_data,
  input  logic             rec_req,
  input  logic [31:0]      rec_fsr,
  input  logic [AW-1:0]    rec_far,
  output logic [AW-1:0]    out_addr,
  output logic             abort_o,
  output logic             bp_event_o,
  output logic [31:0]      fsr_o,
  output logic [AW-1:0]    far_o,
  output logic [31:0]      dsr_o
);
  localparam int NUM_BP = 2;

  logic                     align_fault;
  logic                     bp_hit;
  logic [NUM_BP-1:0][AW-1:0] bp_refs;
  logic [NUM_BP-1:0][1:0]   bp_ens;

  assign bp_refs = {bp_addr1, bp_addr0};
  assign bp_ens  = {bp_en1, bp_en0};

  mac_pid_remap #(.AW(AW), .PID_W(PID_W)) i_remap (
    .addr_in  (acc_addr),
    .pid      (pid_bits),
    .addr_out (out_addr)
  );

  assign align_fault = acc_valid && ctrl_align_en && (out_addr[GRAN_LSB-1:0] != '0);

  mac_dbp_match #(.AW(AW), .GRAN_LSB(GRAN_LSB), .NUM_BP(NUM_BP)) i_match (
    .valid     (acc_valid),
    .addr      (out_addr),
    .is_store  (acc_store),
    .refs      (bp_refs),
    .ens       (bp_ens),
    .mask_mode (bp_mask_mode),
    .hit       (bp_hit)
  );

  mac_status_regs #(
    .AW(AW), .FSR_MASK(FSR_MASK), .ALIGN_CODE(ALIGN_CODE), .DB_CODE(DB_CODE)
  ) i_regs (
    .clk         (clk),
    .rst         (rst),
    .align_fault (align_fault),
    .bp_hit      (bp_hit),
    .fault_addr  (out_addr),
    .dsr_wr_en   (dsr_wr_en),
    .dsr_wr_data (dsr_wr_data),
    .rec_req     (rec_req),
    .rec_fsr     (rec_fsr),
    .rec_far     (rec_far),
    .abort_o     (abort_o),
    .bp_event_o  (bp_event_o),
    .fsr_o       (fsr_o),
    .far_o       (far_o),
    .dsr_o       (dsr_o)
  );
endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
  parameter int AW    = 32,
  parameter int PID_W = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic          ctrl_align_en,
  input logic [1:0]    bp_en0,
  input logic [1:0]    bp_en1,
  input logic          bp_mask_mode,
  input logic          rec_req,
  input logic [AW-1:0] out_addr,
  input logic          abort_o,
  input logic          bp_event_o,
  input logic [31:0]   fsr_o,
  input logic [AW-1:0] far_o,
  input logic [31:0]   dsr_o
);
  localparam int LOW_W = AW - PID_W;

  logic [1:0] settle;
  always_ff @(posedge clk) begin
    if (rst) settle <= '0;
    else if (settle != 2'd2) settle <= settle + 2'd1;
  end

  AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (rst)
    out_addr[LOW_W-1:0] == acc_addr[LOW_W-1:0]); // R2

  AST_HIGH_SLOT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (acc_addr[AW-1:LOW_W] != '0) |-> (out_addr == acc_addr)); // R3

  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> ($past(acc_valid) && $past(ctrl_align_en) && ($past(acc_addr[1:0]) != 2'b00))); // R4

  AST_FAR_MISALIGNED: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (far_o[1:0] != 2'b00)); // R4

  AST_EVENT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    bp_event_o |-> ($past(acc_valid) &&
                    (($past(bp_en0) != 2'd0) || (!$past(bp_mask_mode) && ($past(bp_en1) != 2'd0))))); // R5

  AST_EVENT_CODE: assert property (@(posedge clk) disable iff (rst)
    bp_event_o |-> (dsr_o[4:2] == 3'b010)); // R8

  AST_RECORD_GATED: assert property (@(posedge clk) disable iff (rst)
    ((settle == 2'd2) && (fsr_o != $past(fsr_o))) |->
      (abort_o || ($past(rec_req) && $past(dsr_o[31])))); // R9
endmodule

bind mem_access_checker mac_checker #(.AW(AW), .PID_W(PID_W)) i_mac_checker (
  .clk           (clk),
  .rst           (rst),
  .acc_valid     (acc_valid),
  .acc_addr      (acc_addr),
  .ctrl_align_en (ctrl_align_en),
  .bp_en0        (bp_en0),
  .bp_en1        (bp_en1),
  .bp_mask_mode  (bp_mask_mode),
  .rec_req       (rec_req),
  .out_addr      (out_addr),
  .abort_o       (abort_o),
  .bp_event_o    (bp_event_o),
  .fsr_o         (fsr_o),
  .far_o         (far_o),
  .dsr_o         (dsr_o)
);

// File: tb/test_mem_access_checker.sv
`timescale 1ns/1ps
module test_mem_access_checker;
  localparam logic [31:0] FSR_MASK   = 32'h0000_06FF;
  localparam logic [31:0] ALIGN_CODE = 32'h0000_0001;

  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_store, ctrl_align_en, bp_mask_mode;
  logic [31:0] acc_addr, bp_addr0, bp_addr1, dsr_wr_data, rec_fsr, rec_far;
  logic [6:0]  pid_bits;
  logic [1:0]  bp_en0, bp_en1;
  logic        dsr_wr_en, rec_req;
  logic [31:0] out_addr, fsr_o, far_o, dsr_o;
  logic        abort_o, bp_event_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] m_fsr, m_far, m_dsr;

  always #2.5 clk = ~clk;

  mem_access_checker i_mem_access_checker (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_store(acc_store), .pid_bits(pid_bits), .ctrl_align_en(ctrl_align_en),
    .bp_addr0(bp_addr0), .bp_addr1(bp_addr1), .bp_en0(bp_en0), .bp_en1(bp_en1),
    .bp_mask_mode(bp_mask_mode), .dsr_wr_en(dsr_wr_en), .dsr_wr_data(dsr_wr_data),
    .rec_req(rec_req), .rec_fsr(rec_fsr), .rec_far(rec_far), .out_addr(out_addr),
    .abort_o(abort_o), .bp_event_o(bp_event_o), .fsr_o(fsr_o), .far_o(far_o),
    .dsr_o(dsr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input string ctx);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s): actual %h expected %h", tag, ctx, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [6:0] p);
    if (p != 7'd0 && a[31:25] == 7'd0) return {p, a[24:0]};
    return a;
  endfunction

  function automatic logic kind_ok(input logic [1:0] e, input logic st);
    return (e == 2'd2) || (e == 2'd1 && st) || (e == 2'd3 && !st);
  endfunction

  function automatic logic exp_hit(input logic [31:0] a, input logic st);
    if (bp_mask_mode)
      return kind_ok(bp_en0, st) && ((a & ~bp_addr1) == (bp_addr0 & ~bp_addr1));
    return (kind_ok(bp_en0, st) && a[31:2] == bp_addr0[31:2]) ||
           (kind_ok(bp_en1, st) && a[31:2] == bp_addr1[31:2]);
  endfunction

  // Called away from the clock edge with inputs already applied.
  task automatic step(input string ctx);
    logic [31:0] ea, nf, nfa, nd;
    logic ab, ht;
    #1;
    ea = exp_addr(acc_addr, pid_bits);
    chk("R2", out_addr, ea, ctx);
    ab = acc_valid && ctrl_align_en && (ea[1:0] != 2'b00);
    ht = acc_valid && exp_hit(ea, acc_store);
    nf = m_fsr; nfa = m_far;
    if (ab) begin nf = ALIGN_CODE & FSR_MASK; nfa = ea; end
    else if (rec_req && m_dsr[31]) begin nf = rec_fsr & FSR_MASK; nfa = rec_far; end
    nd = dsr_wr_en ? dsr_wr_data : m_dsr;
    if (ht) nd[4:2] = 3'b010;
    @(posedge clk); #1;
    m_fsr = nf; m_far = nfa; m_dsr = nd;
    chk("R4", {31'd0, abort_o}, {31'd0, ab}, ctx);
    chk("R8", {31'd0, bp_event_o}, {31'd0, ht}, ctx);
    chk("R9", fsr_o, m_fsr, ctx);
    chk("R4", far_o, m_far, ctx);
    chk("R10", dsr_o, m_dsr, ctx);
  endtask

  task automatic quiet();
    acc_valid = 0; acc_store = 0; dsr_wr_en = 0; rec_req = 0;
    dsr_wr_data = '0; rec_fsr = '0; rec_far = '0;
  endtask

  task automatic access(input logic [31:0] a, input logic st);
    quiet(); acc_valid = 1; acc_addr = a; acc_store = st;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    quiet();
    acc_addr = '0; pid_bits = '0; ctrl_align_en = 0; bp_mask_mode = 0;
    bp_addr0 = '0; bp_addr1 = '0; bp_en0 = 0; bp_en1 = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {30'd0, abort_o, bp_event_o}, 32'd0, "reset pulses");
    chk("R1", fsr_o, 32'd0, "reset fsr");
    chk("R1", far_o, 32'd0, "reset far");
    chk("R1", dsr_o, 32'd0, "reset dsr");
    m_fsr = '0; m_far = '0; m_dsr = '0;
    rst = 0;

    // R3: high slot address is left alone
    pid_bits = 7'h05; access(32'h8000_1234, 0); #1;
    chk("R3", out_addr, 32'h8000_1234, "high slot kept");
    pid_bits = 7'h00; access(32'h0000_1234, 0); #1;
    chk("R3", out_addr, 32'h0000_1234, "zero pid");
    step("R3 idle access");

    // R12: breakpoint matches only after rewrite
    pid_bits = 7'h05; bp_addr0 = 32'h0A00_1000; bp_en0 = 2'd2;
    access(32'h0000_1000, 1); step("R12 rewrite");
    chk("R12", {31'd0, bp_event_o}, 32'd1, "hit via rewritten address");
    chk("R8", {29'd0, dsr_o[4:2]}, 32'd2, "entry code");
    pid_bits = 0;

    // R5: kind codes
    bp_addr0 = 32'h0000_0100; bp_en0 = 2'd1;
    access(32'h0000_0100, 0); step("R5"); chk("R5", {31'd0, bp_event_o}, 0, "store-only vs load");
    access(32'h0000_0100, 1); step("R5"); chk("R5", {31'd0, bp_event_o}, 1, "store-only vs store");
    bp_en0 = 2'd3;
    access(32'h0000_0100, 1); step("R5"); chk("R5", {31'd0, bp_event_o}, 0, "load-only vs store");
    access(32'h0000_0100, 0); step("R5"); chk("R5", {31'd0, bp_event_o}, 1, "load-only vs load");
    bp_en0 = 2'd0;
    access(32'h0000_0100, 0); step("R5"); chk("R5", {31'd0, bp_event_o}, 0, "disabled");

    // R6: word granularity, second breakpoint
    bp_en0 = 2'd2; bp_addr1 = 32'h0000_2000; bp_en1 = 2'd2;
    access(32'h0000_0103, 0); step("R6"); chk("R6", {31'd0, bp_event_o}, 1, "low bits ignored bp0");
    bp_en0 = 2'd0;
    access(32'h0000_2002, 1); step("R6"); chk("R6", {31'd0, bp_event_o}, 1, "bp1 hit");
    access(32'h0000_2004, 1); step("R6"); chk("R6", {31'd0, bp_event_o}, 0, "next word misses");

    // R7: mask mode, E1 ignored
    bp_mask_mode = 1; bp_addr0 = 32'h1234_0000; bp_addr1 = 32'h0000_FFFF;
    bp_en0 = 2'd2; bp_en1 = 2'd2;
    access(32'h1234_ABCD, 0); step("R7"); chk("R7", {31'd0, bp_event_o}, 1, "masked hit");
    access(32'h1235_0000, 0); step("R7"); chk("R7", {31'd0, bp_event_o}, 0, "masked miss");
    bp_en0 = 2'd0;
    access(32'h0000_FFFF, 0); step("R7"); chk("R7", {31'd0, bp_event_o}, 0, "E1 has no effect");
    bp_mask_mode = 0; bp_en1 = 0;

    // R4: align disabled, then enabled
    access(32'h0000_0042, 0); step("R4"); chk("R4", {31'd0, abort_o}, 0, "align check off");
    ctrl_align_en = 1; pid_bits = 7'h03;
    access(32'h0000_0042, 1); step("R4");
    chk("R4", {31'd0, abort_o}, 1, "abort");
    chk("R12", far_o, 32'h0600_0042, "far holds rewritten address");
    chk("R4", fsr_o, 32'h0000_0001, "fsr code");
    pid_bits = 0;

    // R9: record gated by debug status top bit
    quiet(); rec_req = 1; rec_fsr = 32'hFFFF_FFFF; rec_far = 32'hCAFE_0000; step("R9");
    chk("R9", fsr_o, 32'h0000_0001, "record blocked");
    quiet(); dsr_wr_en = 1; dsr_wr_data = 32'h8000_0000; step("R10");
    chk("R10", dsr_o, 32'h8000_0000, "dsr write");
    quiet(); rec_req = 1; rec_fsr = 32'hFFFF_FFFF; rec_far = 32'hCAFE_0000; step("R9");
    chk("R9", fsr_o, 32'h0000_06FF, "record masked");
    chk("R9", far_o, 32'hCAFE_0000, "record far");
    access(32'h0000_0011, 0); rec_req = 1; rec_fsr = 32'h0000_0400; rec_far = 32'h1;
    step("R9"); chk("R9", fsr_o, 32'h0000_0001, "abort beats record");
    chk("R9", far_o, 32'h0000_0011, "abort far beats record");

    // R10/R11: write with hit; fault with hit
    bp_addr0 = 32'h0000_0300; bp_en0 = 2'd2;
    access(32'h0000_0301, 1); dsr_wr_en = 1; dsr_wr_data = 32'h0000_00FF; step("R11");
    chk("R10", dsr_o, 32'h0000_00EB, "write plus entry code");
    chk("R11", {30'd0, abort_o, bp_event_o}, 32'd3, "both pulses");
    ctrl_align_en = 0;

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      if (i % 64 == 0) begin
        bp_addr0 = $urandom(); bp_addr1 = $urandom();
        if ($urandom_range(1, 0) == 1) bp_addr1 = $urandom() & 32'h0000_0FFF;
        bp_en0 = 2'($urandom()); bp_en1 = 2'($urandom());
        bp_mask_mode = 1'($urandom()); ctrl_align_en = 1'($urandom());
      end
      quiet();
      acc_valid = ($urandom_range(3, 0) != 0);
      acc_store = 1'($urandom());
      pid_bits  = ($urandom_range(1, 0) == 1) ? 7'($urandom()) : 7'd0;
      case ($urandom_range(3, 0))
        0: acc_addr = bp_addr0 ^ ($urandom() & 32'h3);
        1: acc_addr = bp_addr1 ^ ($urandom() & 32'h3);
        2: acc_addr = $urandom() & 32'h01FF_FFFF;
        default: acc_addr = $urandom();
      endcase
      dsr_wr_en = ($urandom_range(7, 0) == 0);
      dsr_wr_data = $urandom();
      rec_req = ($urandom_range(3, 0) == 0);
      rec_fsr = $urandom(); rec_far = $urandom();
      step("R6 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule